// File: doc/BRIEF.md
# Coarse/fine split-counter PWM generator

This block produces a single pulse-width-modulated output from an N-bit duty word. The word is divided into two fields. The upper COARSE_W bits are compared against a small coarse step counter. The lower FINE_W bits select one tap of a circulating one-hot ring of flip-flops. The ring moves one position per fast clock cycle. One full trip around the ring is one coarse step, so the coarse counter runs 2^FINE_W times slower than the fast clock. The full duty resolution therefore comes from a counter of only COARSE_W bits plus a tap multiplexer.

A switching period lasts 2^(COARSE_W+FINE_W) fast cycles. A period starts when both the counter and the ring are at zero. In that cycle a strobe is raised and the duty word is captured. The output rises in the following cycle. It falls once the coarse counter equals the upper duty field and the circulating bit sits on the tap chosen by the lower field. The high time, counted in fast cycles, therefore equals the captured duty value.

Top module: `split_pwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_out` is low. In the first cycle after `rst` falls, `period_strobe` is high, because the counter and the ring start at zero.
- R2: `period_strobe` is high for exactly one cycle in every 2^(COARSE_W+FINE_W) cycles, and low in all the others.
- R3: The coarse counter holds its value in every cycle except those in which the ring sits at its last tap. In those cycles it advances by one.
- R4: The ring always holds exactly one set bit. That bit moves one tap per cycle, and it returns from the last tap to tap 0.
- R5: Let t count the cycles of a period, with t = 0 in the strobe cycle. For a captured duty value D > 0, `pwm_out` is high exactly for 1 <= t <= D and low otherwise, so the high time is D cycles.
- R6: A captured duty value of 0 keeps `pwm_out` low for the whole period.
- R7: The all-ones duty value gives 2^(COARSE_W+FINE_W) - 1 high cycles. The output is still low in the strobe cycle.
- R8: `duty_in` is sampled only at the clock edge that ends the strobe cycle. Changes at any other time have no effect on the current period.
- R9: The falling edge is placed by both fields together. The last high cycle is the one in which the counter equals duty bits [N-1:FINE_W] and the ring bit is at the tap given by duty bits [FINE_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; the ring advances on every edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | COARSE_W+FINE_W | Duty word, captured at period start |
| pwm_out | output | 1 | Modulated output |
| period_strobe | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The bench runs a small configuration (2 coarse bits, 3 fine bits) through every duty word in ascending order, one word per period. Across adjacent words, only the fine tap differs at times and the coarse match differs at other times, so an error in either field shows up as a wrong high time. Duty 0 and the all-ones word cover the two ends of the range. A further set of scrambled words exercises non-monotonic changes from one period to the next. During every period, `duty_in` is driven to an unrelated value in mid-period and then to the next word. If the captured value leaks through anywhere except at period start, the measured pulse shape changes.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   localparam int unsigned SPWM_MAX_FINE_W   = 10;
   localparam int unsigned SPWM_MAX_COARSE_W = 16;

   function automatic int unsigned spwm_pow2(input int unsigned w);
      return 32'd1 << w;
   endfunction

endpackage

// File: rtl/spwm_ring.sv
module spwm_ring #(
   parameter int unsigned FINE_W = 5
) (
   input  logic                                    clk,
   input  logic                                    rst,
   output logic [spwm_pkg::spwm_pow2(FINE_W)-1:0]  ring_o,
   output logic                                    wrap_o
);
   localparam int unsigned RING_LEN = spwm_pkg::spwm_pow2(FINE_W);

   logic [RING_LEN-1:0] ring_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ring_q <= {{(RING_LEN-1){1'b0}}, 1'b1};
      end else begin
         ring_q <= {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]};
      end
   end

   assign ring_o = ring_q;
   assign wrap_o = ring_q[RING_LEN-1];

   // R4: exactly one circulating bit
   a_r4_ring_onehot: assert property (@(posedge clk) disable iff (rst)
      $countones(ring_q) == 1);

   // R4: last tap is followed by tap 0
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      ring_q[RING_LEN-1] |=> ring_q[0]);

endmodule

// File: rtl/spwm_coarse.sv
module spwm_coarse #(
   parameter int unsigned COARSE_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step_i,
   output logic [COARSE_W-1:0] count_o,
   output logic                zero_o
);
   logic [COARSE_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (step_i) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count_o = count_q;
   assign zero_o  = (count_q == '0);

   // R3: counter holds between ring wraps
   a_r3_hold_without_wrap: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(count_q));

   // R3: counter moves on a wrap
   a_r3_move_on_wrap: assert property (@(posedge clk) disable iff (rst)
      step_i |=> !$stable(count_q));

endmodule

// File: rtl/spwm_tap_mux.sv
module spwm_tap_mux #(
   parameter int unsigned FINE_W        = 5,
   parameter bit          ONEHOT_DECODE = 1'b0
) (
   input  logic [spwm_pkg::spwm_pow2(FINE_W)-1:0] ring_i,
   input  logic [FINE_W-1:0]                      sel_i,
   output logic                                   hit_o
);
   localparam int unsigned RING_LEN = spwm_pkg::spwm_pow2(FINE_W);

   generate
      if (ONEHOT_DECODE) begin : g_decode
         logic [RING_LEN-1:0] sel_dec;
         always_comb begin
            sel_dec        = '0;
            sel_dec[sel_i] = 1'b1;
         end
         assign hit_o = |(sel_dec & ring_i);
      end else begin : g_index
         assign hit_o = ring_i[sel_i];
      end
   endgenerate

endmodule

// File: rtl/split_pwm_gen.sv
module split_pwm_gen #(
   parameter int unsigned COARSE_W      = 3,
   parameter int unsigned FINE_W        = 5,
   parameter bit          ONEHOT_DECODE = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [COARSE_W+FINE_W-1:0] duty_in,
   output logic                       pwm_out,
   output logic                       period_strobe
);
   localparam int unsigned DUTY_W   = COARSE_W + FINE_W;
   localparam int unsigned RING_LEN = spwm_pkg::spwm_pow2(FINE_W);

   generate
      if (FINE_W < 1 || FINE_W > spwm_pkg::SPWM_MAX_FINE_W) begin : g_bad_fine
         $error("split_pwm_gen: FINE_W out of range");
      end
      if (COARSE_W < 1 || COARSE_W > spwm_pkg::SPWM_MAX_COARSE_W) begin : g_bad_coarse
         $error("split_pwm_gen: COARSE_W out of range");
      end
   endgenerate

   logic [RING_LEN-1:0] ring;
   logic                ring_wrap;
   logic [COARSE_W-1:0] coarse_cnt;
   logic                coarse_zero;
   logic                tap_hit;
   logic [DUTY_W-1:0]   duty_q;
   logic                pwm_q;
   logic                start;
   logic                coarse_match;
   logic                fall_now;

   spwm_ring #(.FINE_W(FINE_W)) ring_i (
      .clk    (clk),
      .rst    (rst),
      .ring_o (ring),
      .wrap_o (ring_wrap)
   );

   spwm_coarse #(.COARSE_W(COARSE_W)) coarse_i (
      .clk     (clk),
      .rst     (rst),
      .step_i  (ring_wrap),
      .count_o (coarse_cnt),
      .zero_o  (coarse_zero)
   );

   spwm_tap_mux #(.FINE_W(FINE_W), .ONEHOT_DECODE(ONEHOT_DECODE)) mux_i (
      .ring_i (ring),
      .sel_i  (duty_q[FINE_W-1:0]),
      .hit_o  (tap_hit)
   );

   assign start        = coarse_zero & ring[0];
   assign coarse_match = (coarse_cnt == duty_q[DUTY_W-1:FINE_W]);
   assign fall_now     = coarse_match & tap_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         duty_q <= '0;
      end else if (start) begin
         duty_q <= duty_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_q <= 1'b0;
      end else if (start) begin
         pwm_q <= |duty_in;
      end else if (fall_now) begin
         pwm_q <= 1'b0;
      end
   end

   assign pwm_out       = pwm_q;
   assign period_strobe = start;

   // R5: nonzero duty raises the output right after the strobe
   a_r5_rise_after_start: assert property (@(posedge clk) disable iff (rst)
      (period_strobe && (duty_in != '0)) |=> pwm_out);

   // R5: the output never rises in mid-period
   a_r5_no_mid_rise: assert property (@(posedge clk) disable iff (rst)
      !period_strobe |=> !$rose(pwm_out));

   // R6: zero duty keeps the output low
   a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
      (period_strobe && (duty_in == '0)) |=> !pwm_out);

   // R7: output is low in every strobe cycle
   a_r7_low_at_start: assert property (@(posedge clk) disable iff (rst)
      period_strobe |-> !pwm_out);

   // R8: captured duty stays fixed inside a period
   a_r8_duty_held: assert property (@(posedge clk) disable iff (rst)
      !period_strobe |=> $stable(duty_q));

   // R9: falling only after the combined coarse/fine match
   a_r9_fall_on_match: assert property (@(posedge clk) disable iff (rst)
      (pwm_out && !period_strobe && !fall_now) |=> pwm_out);

endmodule

// File: tb/split_pwm_gen_tb_top.sv
module split_pwm_gen_tb_top;
   localparam int unsigned CW  = 2;
   localparam int unsigned FW  = 3;
   localparam int unsigned NW  = CW + FW;
   localparam int unsigned PER = 1 << NW;
   localparam int unsigned NP  = PER + 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NW-1:0] duty_in = '0;
   logic          pwm_out;
   logic          period_strobe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   split_pwm_gen #(.COARSE_W(CW), .FINE_W(FW), .ONEHOT_DECODE(1'b1)) dut_i (
      .clk           (clk),
      .rst           (rst),
      .duty_in       (duty_in),
      .pwm_out       (pwm_out),
      .period_strobe (period_strobe)
   );

   function automatic int unsigned seq_duty(input int unsigned p);
      if (p < PER) return p;
      return (p * 37 + 11) % PER;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #(20 * 200 * PER);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned exp_d;
      int          high_cnt;
      int          shape_bad;
      int          strobe_bad;
      duty_in = NW'(seq_duty(0));
      repeat (3) @(negedge clk);
      // R1: output low under reset
      check(pwm_out == 1'b0, "R1 pwm low in reset", int'(pwm_out), 0);
      @(posedge clk);
      #1 rst = 1'b0;
      exp_d = 0;
      for (int unsigned p = 0; p < NP; p++) begin
         high_cnt   = 0;
         shape_bad  = 0;
         strobe_bad = 0;
         for (int unsigned t = 0; t < PER; t++) begin
            @(negedge clk);
            if (t == 0) begin
               exp_d = int'(duty_in);
               if (p == 0) check(period_strobe == 1'b1, "R1 strobe after reset",
                                 int'(period_strobe), 1);
            end
            if (period_strobe != (t == 0)) strobe_bad++;
            if (pwm_out) high_cnt++;
            if (pwm_out != (t >= 1 && t <= exp_d)) shape_bad++;
            // R8: disturb the input in mid-period, then set the next word
            if (t == 3)       duty_in = ~NW'(seq_duty(p + 1));
            if (t == PER - 3) duty_in = NW'(seq_duty(p + 1));
         end
         check(strobe_bad == 0, "R2 strobe once per period", strobe_bad, 0);
         if (exp_d == 0)
            check(high_cnt == 0, "R6 zero duty high time", high_cnt, 0);
         else if (exp_d == PER - 1)
            check(high_cnt == PER - 1, "R7 full duty high time", high_cnt, PER - 1);
         else
            check(high_cnt == exp_d, "R5 R3 R4 high time", high_cnt, exp_d);
         check(shape_bad == 0, "R9 R8 edge placement", shape_bad, 0);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule